// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block drives the control strobes of a single asynchronous access on a parallel external memory bus. The strobes are a chip select line for each attached device, an address-valid strobe, a write strobe and a read (output-enable) strobe, all active low. Once a request is accepted, a phase counter runs in controller clock ticks. Each strobe is asserted over a window of phases, and a separate configuration input sets each window's start and end. Chip select and address valid each take one start value and two end values, one for reads and one for writes. The access ends after a programmed read or write cycle length. A one-clock done pulse marks the last phase. A read-capture pulse marks the phase where read data is valid.

Between accesses the block enforces a bus turnaround gap. It can also add a programmable inter-access gap. Two enables choose whether that gap applies when the next access targets the same chip select as the last one, or a different one. A doubling option scales every timing value by two. Each strobe can be moved half a clock later. A requester raises `req_valid` with the operation and the target. The request is taken on the first rising edge at which `req_ready` is high. The configuration must stay stable while an access runs.

Top module: `xbus_strobe_gen`

## Requirements
- R1: After reset every strobe (`cs_n`, `addr_vld_n`, `we_n`, `oe_n`) is high, `acc_done` and `rd_sample` are low, and `req_ready` is high.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The clock interval after that edge is phase 0 and each later interval is the next phase. Only the `cs_n` bit indexed by `req_cs` goes low, during phases p with CS_ON <= p < CS_OFF. CS_OFF is `cfg_cs_wr_off` for writes and `cfg_cs_rd_off` for reads.
- R3: `addr_vld_n` is low during phases p with AV_ON <= p < AV_OFF, using `cfg_av_wr_off` or `cfg_av_rd_off` according to the operation.
- R4: `we_n` is low during phases `cfg_we_on` <= p < `cfg_we_off` of write accesses only, and it stays high during reads.
- R5: `oe_n` is low during phases `cfg_oe_on` <= p < `cfg_oe_off` of read accesses only, and it stays high during writes.
- R6: An access lasts L phases, where L is the cycle value for its operation, or 1 if that value is 0. `acc_done` is high for exactly the phase L-1. No strobe is asserted outside phases 0..L-1, so a window that extends past L is clipped.
- R7: On reads, `rd_sample` is high for one clock in phase `cfg_rd_access` if that phase is below L. It never rises on writes.
- R8: When `cfg_x2` is 1, every timing value (strobe starts and ends, cycle lengths, access, turnaround, gap) counts as twice its programmed value.
- R9: `cfg_half_dly` bit 0 (chip select), bit 1 (address valid), bit 2 (output enable) and bit 3 (write enable) move that strobe's edges to the falling clock edge that follows. In the first half of phase p the strobe then shows its phase p-1 level.
- R10: After an access ends, `req_ready` stays low for N idle intervals before going high. N = TURN plus GAP. GAP counts only when `cfg_gap_same_en` is set and `req_cs` equals the last chip select, or when `cfg_gap_diff_en` is set and it differs. The first access after reset does not wait.
- R11: `req_ready` is low throughout an access.
- R12: With all configuration values zero, an access lasts one phase, asserts no strobe and still pulses `acc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | target chip select index |
| req_ready | output | 1 | request can be taken this cycle |
| cfg_cs_on | input | TW | chip select start phase |
| cfg_cs_rd_off | input | TW | chip select end phase, reads |
| cfg_cs_wr_off | input | TW | chip select end phase, writes |
| cfg_av_on | input | TW | address valid start phase |
| cfg_av_rd_off | input | TW | address valid end phase, reads |
| cfg_av_wr_off | input | TW | address valid end phase, writes |
| cfg_we_on | input | TW | write strobe start phase |
| cfg_we_off | input | TW | write strobe end phase |
| cfg_oe_on | input | TW | read strobe start phase |
| cfg_oe_off | input | TW | read strobe end phase |
| cfg_rd_cycle | input | TW | read access length |
| cfg_wr_cycle | input | TW | write access length |
| cfg_rd_access | input | TW | read data capture phase |
| cfg_turnaround | input | TW | idle cycles after every access |
| cfg_c2c_gap | input | TW | extra inter-access gap |
| cfg_gap_same_en | input | 1 | apply gap for same chip select |
| cfg_gap_diff_en | input | 1 | apply gap for different chip select |
| cfg_half_dly | input | 4 | per-strobe half-clock delay |
| cfg_x2 | input | 1 | double all timing values |
| cs_n | output | NCS | chip selects, active low |
| addr_vld_n | output | 1 | address valid, active low |
| we_n | output | 1 | write strobe, active low |
| oe_n | output | 1 | read strobe, active low |
| rd_sample | output | 1 | read data capture pulse |
| acc_done | output | 1 | last phase of the access |

## Verification
The read-capture pulse and the done pulse fall in the same cycle when the scaled access value equals the last phase of a read. The sweep derives its access and cycle values from different arithmetic progressions, so that coincidence occurs several times. That includes the one-phase case, where both pulses sit in phase 0. In each phase both outputs are compared on their own against values the bench computes from the requirement formulas. A design that lets one pulse mask the other, or that lets the end of the access win over the capture, fails in exactly those phases.

// File: rtl/xbus_tmg_pkg.sv
`timescale 1ns/1ps
package xbus_tmg_pkg;
   // strobe slots; the numbering is also the bit order of the half-delay field
   localparam int NSTB   = 4;
   localparam int STB_CS = 0;
   localparam int STB_AV = 1;
   localparam int STB_OE = 2;
   localparam int STB_WE = 3;
endpackage

// File: rtl/xbus_phase_ctl.sv
`timescale 1ns/1ps
module xbus_phase_ctl #(
   parameter int PW  = 6,
   parameter int GW  = 7,
   parameter int CSW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           req_write,
   input  logic [CSW-1:0] req_cs,
   input  logic [PW-1:0]  rd_len,
   input  logic [PW-1:0]  wr_len,
   input  logic [PW-1:0]  rd_acc,
   input  logic [GW-1:0]  need_same,
   input  logic [GW-1:0]  need_diff,
   output logic           ready,
   output logic           act_nxt,
   output logic [PW-1:0]  ph_nxt,
   output logic           wr_nxt,
   output logic           act_q,
   output logic           wr_q,
   output logic [CSW-1:0] cs_q,
   output logic           done_q,
   output logic           smp_q
);
   localparam logic [GW-1:0] IDLE_MAX = '1;

   logic [PW-1:0]  ph_q;
   logic [GW-1:0]  idle_q;
   logic [GW-1:0]  need;
   logic [CSW-1:0] cs_nxt;
   logic [PW-1:0]  len_cur;
   logic [PW-1:0]  len_nxt;
   logic           start;
   logic           last;

   assign need    = (req_cs == cs_q) ? need_same : need_diff;
   assign ready   = !act_q && (idle_q >= need);
   assign start   = req_valid && ready;
   assign len_cur = wr_q ? wr_len : rd_len;
   assign last    = act_q && (ph_q == len_cur - 1'b1);

   always_comb begin
      act_nxt = 1'b0;
      ph_nxt  = '0;
      wr_nxt  = wr_q;
      cs_nxt  = cs_q;
      if (start) begin
         act_nxt = 1'b1;
         wr_nxt  = req_write;
         cs_nxt  = req_cs;
      end else if (act_q && !last) begin
         act_nxt = 1'b1;
         ph_nxt  = ph_q + 1'b1;
      end
   end

   assign len_nxt = wr_nxt ? wr_len : rd_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ph_q   <= '0;
         wr_q   <= 1'b0;
         cs_q   <= '0;
         idle_q <= IDLE_MAX;
         done_q <= 1'b0;
         smp_q  <= 1'b0;
      end else begin
         act_q  <= act_nxt;
         ph_q   <= ph_nxt;
         wr_q   <= wr_nxt;
         cs_q   <= cs_nxt;
         if (act_q || start)
            idle_q <= '0;
         else if (idle_q != IDLE_MAX)
            idle_q <= idle_q + 1'b1;
         done_q <= act_nxt && (ph_nxt == len_nxt - 1'b1);
         smp_q  <= act_nxt && !wr_nxt && (ph_nxt == rd_acc);
      end
   end

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R6
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !act_q);
   // R2
   accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(req_valid));
endmodule

// File: rtl/xbus_strobe.sv
`timescale 1ns/1ps
module xbus_strobe #(
   parameter int PW      = 6,
   parameter bit HALF_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_nxt,
   input  logic [PW-1:0] ph_nxt,
   input  logic [PW-1:0] on_t,
   input  logic [PW-1:0] off_t,
   input  logic          op_en,
   input  logic          half_sel,
   output logic          pos_q,
   output logic          asserted
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= 1'b0;
      else        pos_q <= act_nxt && op_en && (ph_nxt >= on_t) && (ph_nxt < off_t);
   end

   generate
      if (HALF_EN) begin : g_half
         logic neg_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) neg_q <= 1'b0;
            else        neg_q <= pos_q;
         end
         assign asserted = half_sel ? neg_q : pos_q;
      end else begin : g_full
         logic unused_half;
         assign unused_half = half_sel;
         assign asserted    = pos_q;
      end
   endgenerate
endmodule

// File: rtl/xbus_strobe_gen.sv
`timescale 1ns/1ps
module xbus_strobe_gen #(
   parameter int NCS     = 4,
   parameter int TW      = 5,
   parameter bit HALF_EN = 1'b1,
   localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           req_write,
   input  logic [CSW-1:0] req_cs,
   output logic           req_ready,
   input  logic [TW-1:0]  cfg_cs_on,
   input  logic [TW-1:0]  cfg_cs_rd_off,
   input  logic [TW-1:0]  cfg_cs_wr_off,
   input  logic [TW-1:0]  cfg_av_on,
   input  logic [TW-1:0]  cfg_av_rd_off,
   input  logic [TW-1:0]  cfg_av_wr_off,
   input  logic [TW-1:0]  cfg_we_on,
   input  logic [TW-1:0]  cfg_we_off,
   input  logic [TW-1:0]  cfg_oe_on,
   input  logic [TW-1:0]  cfg_oe_off,
   input  logic [TW-1:0]  cfg_rd_cycle,
   input  logic [TW-1:0]  cfg_wr_cycle,
   input  logic [TW-1:0]  cfg_rd_access,
   input  logic [TW-1:0]  cfg_turnaround,
   input  logic [TW-1:0]  cfg_c2c_gap,
   input  logic           cfg_gap_same_en,
   input  logic           cfg_gap_diff_en,
   input  logic [3:0]     cfg_half_dly,
   input  logic           cfg_x2,
   output logic [NCS-1:0] cs_n,
   output logic           addr_vld_n,
   output logic           we_n,
   output logic           oe_n,
   output logic           rd_sample,
   output logic           acc_done
);
   import xbus_tmg_pkg::*;

   localparam int PW = TW + 1;   // scaled timing value
   localparam int GW = TW + 2;   // turnaround plus gap, scaled

   generate
      if (NCS < 2 || NCS > 64) begin : g_bad_ncs
         $error("xbus_strobe_gen: NCS out of range");
      end
      if (TW < 2 || TW > 12) begin : g_bad_tw
         $error("xbus_strobe_gen: TW out of range");
      end
   endgenerate

   function automatic logic [PW-1:0] scl(input logic [TW-1:0] v, input logic dbl);
      return dbl ? {v, 1'b0} : {1'b0, v};
   endfunction

   function automatic logic [PW-1:0] atleast1(input logic [PW-1:0] v);
      return (v == '0) ? PW'(1) : v;
   endfunction

   logic [PW-1:0]  rd_len, wr_len, rd_acc;
   logic [GW-1:0]  turn_s, gap_s, need_same, need_diff;
   logic           act_nxt, wr_nxt, act_q, wr_q, done_q, smp_q;
   logic [PW-1:0]  ph_nxt;
   logic [CSW-1:0] cs_q;

   assign rd_len    = atleast1(scl(cfg_rd_cycle, cfg_x2));
   assign wr_len    = atleast1(scl(cfg_wr_cycle, cfg_x2));
   assign rd_acc    = scl(cfg_rd_access, cfg_x2);
   assign turn_s    = GW'(scl(cfg_turnaround, cfg_x2));
   assign gap_s     = GW'(scl(cfg_c2c_gap, cfg_x2));
   assign need_same = turn_s + (cfg_gap_same_en ? gap_s : '0);
   assign need_diff = turn_s + (cfg_gap_diff_en ? gap_s : '0);

   xbus_phase_ctl #(.PW(PW), .GW(GW), .CSW(CSW)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_cs    (req_cs),
      .rd_len    (rd_len),
      .wr_len    (wr_len),
      .rd_acc    (rd_acc),
      .need_same (need_same),
      .need_diff (need_diff),
      .ready     (req_ready),
      .act_nxt   (act_nxt),
      .ph_nxt    (ph_nxt),
      .wr_nxt    (wr_nxt),
      .act_q     (act_q),
      .wr_q      (wr_q),
      .cs_q      (cs_q),
      .done_q    (done_q),
      .smp_q     (smp_q)
   );

   assign acc_done  = done_q;
   assign rd_sample = smp_q;

   logic [PW-1:0]   on_v  [NSTB];
   logic [PW-1:0]   off_v [NSTB];
   logic [NSTB-1:0] en_v, pos_v, asr_v;

   assign on_v[STB_CS]  = scl(cfg_cs_on, cfg_x2);
   assign off_v[STB_CS] = scl(wr_nxt ? cfg_cs_wr_off : cfg_cs_rd_off, cfg_x2);
   assign en_v[STB_CS]  = 1'b1;
   assign on_v[STB_AV]  = scl(cfg_av_on, cfg_x2);
   assign off_v[STB_AV] = scl(wr_nxt ? cfg_av_wr_off : cfg_av_rd_off, cfg_x2);
   assign en_v[STB_AV]  = 1'b1;
   assign on_v[STB_OE]  = scl(cfg_oe_on, cfg_x2);
   assign off_v[STB_OE] = scl(cfg_oe_off, cfg_x2);
   assign en_v[STB_OE]  = !wr_nxt;
   assign on_v[STB_WE]  = scl(cfg_we_on, cfg_x2);
   assign off_v[STB_WE] = scl(cfg_we_off, cfg_x2);
   assign en_v[STB_WE]  = wr_nxt;

   generate
      for (genvar s = 0; s < NSTB; s++) begin : g_stb
         xbus_strobe #(.PW(PW), .HALF_EN(HALF_EN)) u_stb (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_nxt  (act_nxt),
            .ph_nxt   (ph_nxt),
            .on_t     (on_v[s]),
            .off_t    (off_v[s]),
            .op_en    (en_v[s]),
            .half_sel (cfg_half_dly[s]),
            .pos_q    (pos_v[s]),
            .asserted (asr_v[s])
         );
      end
      for (genvar c = 0; c < NCS; c++) begin : g_csdec
         assign cs_n[c] = !(asr_v[STB_CS] && (cs_q == CSW'(c)));
      end
   endgenerate

   assign addr_vld_n = !asr_v[STB_AV];
   assign oe_n       = !asr_v[STB_OE];
   assign we_n       = !asr_v[STB_WE];

   // R2
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> (pos_v == '0));
   // R4
   we_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_q |-> !pos_v[STB_WE]);
   // R5
   oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !pos_v[STB_OE]);
   // R7
   smp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sample |-> (act_q && !wr_q));
   // R11
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> !req_ready);
endmodule

// File: tb/xbus_strobe_gen_tb.sv
`timescale 1ns/1ps
module xbus_strobe_gen_tb_top;
   localparam int NCS = 4;
   localparam int TW  = 5;
   localparam int CSW = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_write, req_ready;
   logic [CSW-1:0] req_cs;
   logic [TW-1:0] cs_on, cs_rd_off, cs_wr_off, av_on, av_rd_off, av_wr_off;
   logic [TW-1:0] we_on, we_off, oe_on, oe_off, rd_cyc, wr_cyc, rd_acc, turn, gap;
   logic same_en, diff_en, x2;
   logic [3:0] half;
   logic [NCS-1:0] cs_n;
   logic addr_vld_n, we_n, oe_n, rd_sample, acc_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xbus_strobe_gen #(.NCS(NCS), .TW(TW), .HALF_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_cs(req_cs), .req_ready(req_ready),
      .cfg_cs_on(cs_on), .cfg_cs_rd_off(cs_rd_off), .cfg_cs_wr_off(cs_wr_off),
      .cfg_av_on(av_on), .cfg_av_rd_off(av_rd_off), .cfg_av_wr_off(av_wr_off),
      .cfg_we_on(we_on), .cfg_we_off(we_off), .cfg_oe_on(oe_on), .cfg_oe_off(oe_off),
      .cfg_rd_cycle(rd_cyc), .cfg_wr_cycle(wr_cyc), .cfg_rd_access(rd_acc),
      .cfg_turnaround(turn), .cfg_c2c_gap(gap), .cfg_gap_same_en(same_en),
      .cfg_gap_diff_en(diff_en), .cfg_half_dly(half), .cfg_x2(x2),
      .cs_n(cs_n), .addr_vld_n(addr_vld_n), .we_n(we_n), .oe_n(oe_n),
      .rd_sample(rd_sample), .acc_done(acc_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // R8: all timing values scale by two when x2 is set
   function automatic int sc(input int v);
      return x2 ? 2 * v : v;
   endfunction

   function automatic bit win(input int k, input int on, input int off);
      return (k >= 0) && (k >= sc(on)) && (k < sc(off));
   endfunction

   function automatic int csv(input bit low, input int cs);
      return low ? (((1 << NCS) - 1) & ~(1 << cs)) : ((1 << NCS) - 1);
   endfunction

   task automatic set_cfg(input int i);
      cs_on = TW'(i % 3);        cs_rd_off = TW'((i * 5) % 7);  cs_wr_off = TW'((i * 3) % 8);
      av_on = TW'((i / 3) % 3);  av_rd_off = TW'((i * 7) % 6);  av_wr_off = TW'((i / 2) % 7);
      we_on = TW'((i / 4) % 3);  we_off = TW'((i * 11) % 9);
      oe_on = TW'((i / 5) % 4);  oe_off = TW'((i * 13) % 8);
      rd_cyc = TW'((i * 3) % 10); wr_cyc = TW'((i * 7) % 11); rd_acc = TW'((i * 5) % 9);
      turn = TW'((i / 7) % 4);   gap = TW'((i * 3) % 5);
      same_en = i[1];            diff_en = i[2];
      half = 4'((i / 3) % 16);   x2 = i[4];
   endtask

   task automatic run_access(input int idx, input bit wr, input int cs, input int prev);
      int waits = 0;
      int need;
      int len;
      int k;
      bit e_cs, e_av, e_oe, e_we;
      string t8;
      need = 0;
      if (prev >= 0)
         need = sc(int'(turn)) + (((cs == prev) ? same_en : diff_en) ? sc(int'(gap)) : 0);
      req_cs = CSW'(cs); req_write = wr; req_valid = 1'b1;
      while (1) begin
         #7;
         if (req_ready || waits > 300) break;
         // R6: no strobe while idle
         chk(cs_n == 4'hF && addr_vld_n && we_n && oe_n, "R6 idle strobes",
             int'({cs_n, addr_vld_n, we_n, oe_n}), 127);
         waits++;
         @(posedge clk); #1;
      end
      // R10: gap length, same vs different chip select
      chk(waits == need, $sformatf("R10 gap access %0d", idx), waits, need);
      @(posedge clk); #1;
      req_valid = 1'b0;
      len = sc(wr ? int'(wr_cyc) : int'(rd_cyc));
      if (len == 0) len = 1;
      t8 = (x2 ? "R8 " : "");
      for (k = 0; k < len; k++) begin
         #2;
         // first half of phase k: delayed strobes still show phase k-1 (R9)
         e_cs = win(half[0] ? k - 1 : k, cs_on, wr ? cs_wr_off : cs_rd_off);
         e_av = win(half[1] ? k - 1 : k, av_on, wr ? av_wr_off : av_rd_off);
         e_oe = !wr && win(half[2] ? k - 1 : k, oe_on, oe_off);
         e_we = wr && win(half[3] ? k - 1 : k, we_on, we_off);
         chk(int'(cs_n) == csv(e_cs, cs), $sformatf("R2 R9 %scs early a%0d p%0d", t8, idx, k),
             int'(cs_n), csv(e_cs, cs));
         chk(addr_vld_n == !e_av, $sformatf("R3 R9 %sav early a%0d p%0d", t8, idx, k),
             int'(addr_vld_n), int'(!e_av));
         chk(oe_n == !e_oe, $sformatf("R5 R9 %soe early a%0d p%0d", t8, idx, k),
             int'(oe_n), int'(!e_oe));
         chk(we_n == !e_we, $sformatf("R4 R9 %swe early a%0d p%0d", t8, idx, k),
             int'(we_n), int'(!e_we));
         #5;
         e_cs = win(k, cs_on, wr ? cs_wr_off : cs_rd_off);
         e_av = win(k, av_on, wr ? av_wr_off : av_rd_off);
         e_oe = !wr && win(k, oe_on, oe_off);
         e_we = wr && win(k, we_on, we_off);
         chk(int'(cs_n) == csv(e_cs, cs), $sformatf("R2 %scs late a%0d p%0d", t8, idx, k),
             int'(cs_n), csv(e_cs, cs));
         chk(addr_vld_n == !e_av, $sformatf("R3 %sav late a%0d p%0d", t8, idx, k),
             int'(addr_vld_n), int'(!e_av));
         chk(oe_n == !e_oe, $sformatf("R5 %soe late a%0d p%0d", t8, idx, k),
             int'(oe_n), int'(!e_oe));
         chk(we_n == !e_we, $sformatf("R4 %swe late a%0d p%0d", t8, idx, k),
             int'(we_n), int'(!e_we));
         chk(acc_done == (k == len - 1),
             $sformatf("%s %sdone a%0d p%0d", (idx == 0) ? "R12" : "R6", t8, idx, k),
             int'(acc_done), int'(k == len - 1));
         chk(rd_sample == (!wr && k == sc(int'(rd_acc))), $sformatf("R7 %ssample a%0d p%0d", t8, idx, k),
             int'(rd_sample), int'(!wr && k == sc(int'(rd_acc))));
         chk(!req_ready, $sformatf("R11 busy a%0d p%0d", idx, k), int'(req_ready), 0);
         @(posedge clk); #1;
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cs = '0;
      set_cfg(0);
      repeat (3) @(posedge clk);
      #3;
      // R1: reset state
      chk(cs_n == 4'hF && addr_vld_n && we_n && oe_n, "R1 strobes in reset",
          int'({cs_n, addr_vld_n, we_n, oe_n}), 127);
      @(posedge clk); #1;
      rst_n = 1'b1;
      #7;
      chk(req_ready && !acc_done && !rd_sample, "R1 after reset",
          int'({req_ready, acc_done, rd_sample}), 4);
      chk(cs_n == 4'hF && addr_vld_n && we_n && oe_n, "R1 strobes after reset",
          int'({cs_n, addr_vld_n, we_n, oe_n}), 127);
      @(posedge clk); #1;
      begin
         int prev = -1;
         for (int i = 0; i < 160; i++) begin
            int cs = (i / 3) % NCS;
            bit wr = ((i / 2) % 2) == 1;
            set_cfg(i);
            run_access(i, wr, cs, prev);
            prev = cs;
         end
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL R11 watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule